// File: doc/BRIEF.md
# Memory-Mapped MDIO Management Master

This block lets a processor reach the management registers of external Ethernet PHYs and switches over the two-wire management bus (MDC clock, bidirectional MDIO data). Software talks to it through a small 32-bit register port. It places a PHY address and register number in an address word. For a write, it also loads a data word. It then starts the transfer through a command word, and the same word reports a busy flag. The block builds the 64-bit management frame, shifts it out MSB first on a divided clock, turns the data line around for reads, and captures the returned 16 bits into a read-data register.

The expected software sequence is: poll until busy reads 0, program the address (and the write data), write the command word with the start bit set and the access code, poll busy again, and, for a read, fetch the result. The MDIO pad is exposed as a separate output, output-enable and input so that the tri-state buffer sits in the pad ring.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register offsets are address word 0x44, write data 0x48, read data 0x4C and command 0x50. The address word keeps bits 15:0 (PHY address in 15:8, register number in 7:0). Write data keeps bits 15:0. Unused upper bits read 0, the read-data register ignores writes, and every other offset reads 0.
- R2: In the command word, bit 0 is the access code (0 = read, 1 = write) and reads back as written. Bit 8 is the start trigger and always reads 0. Bit 16 is a read-only busy flag. A command write without bit 8 starts nothing.
- R3: An accepted start raises busy in the next cycle. Busy then stays high for exactly 128 × CLK_HALF cycles, which is the whole 64-bit frame.
- R4: A command write that arrives while busy is 1 is ignored entirely: the frame in flight, its length and the stored access code are unchanged.
- R5: The frame goes out MSB first, one bit per MDC period. It consists of 32 ones, start pattern 01, opcode 10 for a read or 01 for a write, then the low 5 bits of the PHY address byte, then the low 5 bits of the register byte.
- R6: In a write frame, the turnaround bits are driven as 1 then 0. They are followed by write-data bits 15:0. The line is driven for all 64 bits.
- R7: In a read frame, the master releases MDIO from bit 46 (both turnaround bits) to the end of the frame. It samples the 16 data bits on MDC rising edges. When busy falls, the read-data register holds these bits in bits 15:0, first bit received in bit 15.
- R8: The read-data register changes only when a read frame completes. A write frame, or a read still in progress, leaves it unchanged.
- R9: MDC stays low while idle. During a frame it has 64 rising edges, each half period is CLK_HALF system clocks, and MDIO output changes only after MDC falling edges.
- R10: MDIO is released (output-enable 0) whenever no frame is in progress.
- R11: A synchronous active-low reset clears all registers, forces MDC low, releases MDIO and clears busy. This also applies when the reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
A wrong bit index or a bad turnaround control shows at once on the pins. A corrupted field then appears on the wire within one MDC period of the bit concerned. The line-driven pattern during the turnaround shows within the same two MDC periods. A divider or sequence counter that slips changes the length of the busy window, which shows as soon as busy falls, about 1280 cycles after the start. Errors in the capture path stay hidden until busy falls, when the read-data register is compared against the pattern the PHY model returned. A write that disturbs that register shows on the next readback.

// File: rtl/mdio_mst_pkg.sv
// Shared constants and types for the MDIO management master.
// Assumes a 64-bit management frame with a 32-bit preamble.
package mdio_mst_pkg;

    localparam int REG_W      = 32;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int DATA_IDX   = 48;   // first data bit

    localparam logic [7:0] OFS_ADDR  = 8'h44;
    localparam logic [7:0] OFS_WDATA = 8'h48;
    localparam logic [7:0] OFS_RDATA = 8'h4C;
    localparam logic [7:0] OFS_CMD   = 8'h50;

    localparam int OP_BIT    = 0;
    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mdio_op_e;

    typedef struct packed {
        logic [4:0]        phy;
        logic [4:0]        regn;
        logic [DATA_W-1:0] wdata;
        mdio_op_e          op;
    } mdio_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator. It runs only while a frame is active and otherwise holds
// MDC low. It toggles every HALF system clocks and flags the clock edge at
// which MDC rises or falls.
// Assumes HALF >= 1.
module mdio_clk_div #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == CNT_MAX);
    assign rise_evt = wrap && !mdc_q;
    assign fall_evt = wrap && mdc_q;
    assign mdc      = mdc_q;

    // Half-period counter and MDC toggle, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    wire unused_chk_dummy = 1'b0;
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $rose(mdc_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/mdio_frame_eng.sv
// Frame sequencer. It latches a request on start, walks 64 bit slots
// advanced on MDC falling edges, drives or releases MDIO per slot, shifts
// read data in on MDC rising edges and commits it when a read frame ends.
// Assumes rise_evt/fall_evt come from a divider that runs while busy is high.
module mdio_frame_eng
    import mdio_mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       body_q;
    logic              rd_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] rdata_q;
    logic              is_rd;

    assign is_rd = (req.op == OP_READ);

    // Slot sequencing, request latch, capture and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            body_q  <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
            rdata_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            rd_q   <= is_rd;
            cap_q  <= '0;
            body_q <= {2'b01, (is_rd ? 2'b10 : 2'b01), req.phy, req.regn,
                       (is_rd ? 2'b11 : 2'b10),
                       (is_rd ? {DATA_W{1'b1}} : req.wdata)};
        end else if (busy_q) begin
            if (rise_evt && rd_q && (idx_q >= IDX_W'(DATA_IDX)))
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            if (fall_evt) begin
                if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                    busy_q <= 1'b0;
                    if (rd_q)
                        rdata_q <= cap_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Pin values for the current slot: preamble ones, then the body MSB first.
    always_comb begin
        mdio_o  = busy_q && (!idx_q[IDX_W-1] || body_q[~idx_q[4:0]]);
        mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_IDX)));
    end

    assign busy  = busy_q;
    assign rdata = rdata_q;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(busy_q) |-> $stable(rdata_q));

endmodule

// File: rtl/mdio_csr.sv
// Register port. It holds the address and write-data words and the access
// code, decodes a start request and returns read data for the current
// offset. Offsets not decoded read 0.
// Assumes a single-cycle write strobe and a combinational read.
module mdio_csr
    import mdio_mst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rdata,
    output logic              start,
    output mdio_req_t         req
);
    logic [15:0]       addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic              op_q;
    logic              hit_addr, hit_wdat, hit_rdat, hit_cmd;

    assign hit_addr = (bus_addr == ADDR_W'(OFS_ADDR));
    assign hit_wdat = (bus_addr == ADDR_W'(OFS_WDATA));
    assign hit_rdat = (bus_addr == ADDR_W'(OFS_RDATA));
    assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));

    // Software-writable words; a command write while busy is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
            op_q   <= 1'b0;
        end else if (bus_wen) begin
            if (hit_addr) addr_q <= bus_wdata[15:0];
            if (hit_wdat) wdat_q <= bus_wdata[DATA_W-1:0];
            if (hit_cmd && !busy) op_q <= bus_wdata[OP_BIT];
        end
    end

    // Start request and the request fields that go with it.
    always_comb begin
        start     = bus_wen && hit_cmd && bus_wdata[START_BIT] && !busy;
        req.phy   = addr_q[12:8];
        req.regn  = addr_q[4:0];
        req.wdata = wdat_q;
        req.op    = mdio_op_e'(bus_wdata[OP_BIT]);
    end

    // Read mux for the current offset.
    always_comb begin
        bus_rdata = '0;
        if (hit_addr) bus_rdata[15:0] = addr_q;
        if (hit_wdat) bus_rdata[DATA_W-1:0] = wdat_q;
        if (hit_rdat) bus_rdata[DATA_W-1:0] = rdata;
        if (hit_cmd) begin
            bus_rdata[OP_BIT]   = op_q;
            bus_rdata[BUSY_BIT] = busy;
        end
    end

    // R4
    busy_cmd_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && hit_cmd && busy) |=> $stable(op_q));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top of the MDIO management master: register port, MDC divider and frame
// sequencer. MDIO is split into output, enable and input for the pad ring.
// Assumes CLK_HALF system clocks per MDC half period (10 at 50 MHz -> 2.5 MHz).
module mdio_mgmt_ctrl
    import mdio_mst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CLK_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int FRAME_CYC = 2 * FRAME_BITS * CLK_HALF;
    localparam int BC_W      = $clog2(FRAME_CYC + 1);

    logic              busy, start, rise_evt, fall_evt;
    logic [DATA_W-1:0] rdata;
    mdio_req_t         req;

    mdio_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rdata(rdata), .start(start), .req(req)
    );

    mdio_clk_div #(.HALF(CLK_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .mdc(mdc), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
    );

    // Busy-window length counter used only by the checks below.
    logic [BC_W-1:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cyc <= '0;
        else                 busy_cyc <= busy_cyc + 1'b1;
    end

    // R3
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cyc == BC_W'(FRAME_CYC)));

    // R10
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mdc && !mdio_oe));

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
// Directed bench: each task runs one scenario and checks its own results.
// A small PHY model logs the MDIO bits on MDC rises and returns read data.
module tb_mdio_mgmt_ctrl;
    localparam int HALF = 10;
    localparam int FRAME_CYC = 128 * HALF;
    localparam logic [7:0] A_ADDR = 8'h44, A_WDAT = 8'h48,
                           A_RDAT = 8'h4C, A_CMD = 8'h50;

    logic        clk = 0, rst_n = 0, bus_wen = 0, mdio_i = 1;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        mdc, mdio_o, mdio_oe;

    int nchk = 0, nfail = 0;
    int rises = 0, base = 0;
    logic [63:0] seen_o, seen_oe;
    logic [15:0] pat;

    mdio_mgmt_ctrl #(.ADDR_W(8), .CLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // PHY model: log the pins at each MDC rise.
    always @(posedge mdc) begin
        int k;
        k = rises - base;
        if (k >= 0 && k < 64) begin
            seen_o[63-k]  = mdio_o;
            seen_oe[63-k] = mdio_oe;
        end
        rises = rises + 1;
    end

    // PHY model: present the next read-data bit after each MDC fall.
    always @(negedge mdc) begin
        int k;
        k = rises - base;
        if (k >= 48 && k < 64) mdio_i = pat[63-k];
        else                   mdio_i = 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1;
        @(negedge clk);
        bus_wen = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One transfer; counts busy cycles, optionally injects a command write
    // while busy and samples the read-data register mid-frame.
    task automatic xfer(input bit wr, input logic [7:0] phy, input logic [7:0] rg,
                        input logic [15:0] wd, input logic [15:0] rpat,
                        input bit inject, output int cyc, output logic [15:0] mid);
        logic [31:0] r;
        pat = rpat;
        mid = 16'h0;
        bus_wr(A_ADDR, {16'h0, phy, rg});
        bus_wr(A_WDAT, {16'h0, wd});
        base = rises;
        bus_wr(A_CMD, 32'h100 | 32'(wr));
        cyc = 0;
        bus_rd(A_CMD, r);
        while (r[16] && cyc < 5000) begin
            cyc++;
            if (cyc == 200 && inject) begin
                bus_wr(A_CMD, 32'h100 | 32'(!wr));
                cyc += 2;
            end
            if (cyc == 600) begin
                bus_rd(A_RDAT, r);
                mid = r[15:0];
            end
            @(negedge clk);
            bus_rd(A_CMD, r);
        end
    endtask

    function automatic logic [63:0] frame(input bit wr, input logic [7:0] phy,
                                          input logic [7:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy[4:0], rg[4:0],
                (wr ? 2'b10 : 2'b11), (wr ? wd : 16'hFFFF)};
    endfunction

    task automatic t_reset_state();
        logic [31:0] r;
        bus_rd(A_ADDR, r); chk("R11 addr after reset", 64'(r), 64'h0);
        bus_rd(A_WDAT, r); chk("R11 wdata after reset", 64'(r), 64'h0);
        bus_rd(A_RDAT, r); chk("R11 rdata after reset", 64'(r), 64'h0);
        bus_rd(A_CMD, r);  chk("R11 cmd after reset", 64'(r), 64'h0);
        chk("R11 mdc/oe after reset", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    task automatic t_registers();
        logic [31:0] r;
        bus_wr(A_ADDR, 32'hABCD_1F0A);
        bus_rd(A_ADDR, r); chk("R1 addr word mask", 64'(r), 64'h1F0A);
        bus_wr(A_WDAT, 32'h1234_BEEF);
        bus_rd(A_WDAT, r); chk("R1 wdata mask", 64'(r), 64'hBEEF);
        bus_wr(A_RDAT, 32'hFFFF_FFFF);
        bus_rd(A_RDAT, r); chk("R1 rdata ignores writes", 64'(r), 64'h0);
        bus_rd(8'h40, r);  chk("R1 undefined 0x40", 64'(r), 64'h0);
        bus_rd(8'h54, r);  chk("R1 undefined 0x54", 64'(r), 64'h0);
        bus_rd(8'h46, r);  chk("R1 undefined 0x46", 64'(r), 64'h0);
        bus_wr(A_CMD, 32'h0000_0001);
        @(negedge clk);
        bus_rd(A_CMD, r);  chk("R2 op readback, no start", 64'(r), 64'h1);
        chk("R2 no mdc without start", 64'(mdc), 64'h0);
    endtask

    task automatic t_write(input bit inject);
        int cyc; logic [15:0] mid; logic [31:0] r;
        xfer(1'b1, 8'h03, 8'h11, 16'hA55A, 16'h0, inject, cyc, mid);
        chk(inject ? "R4 busy length with mid start" : "R3 busy length", 64'(cyc), 64'(FRAME_CYC));
        chk("R9 mdc rises per frame", 64'(rises - base), 64'd64);
        chk(inject ? "R4 frame untouched" : "R5 R6 write frame", seen_o, frame(1'b1, 8'h03, 8'h11, 16'hA55A));
        chk("R6 driven every bit", seen_oe, {64{1'b1}});
        chk("R10 idle pins after write", {62'h0, mdc, mdio_oe}, 64'h0);
        bus_rd(A_CMD, r);
        chk("R4 op code kept", 64'(r), 64'h1);
    endtask

    task automatic t_read(input logic [7:0] phy, input logic [7:0] rg,
                          input logic [15:0] rp, input logic [15:0] prev);
        int cyc; logic [15:0] mid; logic [31:0] r;
        xfer(1'b0, phy, rg, 16'h0, rp, 1'b0, cyc, mid);
        chk("R3 read busy length", 64'(cyc), 64'(FRAME_CYC));
        chk("R5 read header", {18'h0, seen_o[63:18]}, {18'h0, frame(1'b0, phy, rg, 16'h0) >> 18});
        chk("R7 release from turnaround", seen_oe, {{46{1'b1}}, 18'h0});
        chk("R8 rdata stable mid read", 64'(mid), 64'(prev));
        bus_rd(A_RDAT, r);
        chk("R7 captured read data", 64'(r), 64'(rp));
    endtask

    task automatic t_write_keeps_rdata(input logic [15:0] prev);
        logic [31:0] r;
        t_write(1'b1);
        bus_rd(A_RDAT, r);
        chk("R8 rdata kept across write", 64'(r), 64'(prev));
    endtask

    task automatic t_reset_mid();
        int cyc; logic [31:0] r;
        bus_wr(A_ADDR, 32'h0000_0102);
        bus_wr(A_CMD, 32'h100);
        repeat (300) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R11 mid-frame reset pins", {61'h0, mdc, mdio_oe, mdio_o}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        bus_rd(A_CMD, r);  chk("R11 busy cleared", 64'(r), 64'h0);
        bus_rd(A_RDAT, r); chk("R11 rdata cleared", 64'(r), 64'h0);
        bus_rd(A_ADDR, r); chk("R11 addr cleared", 64'(r), 64'h0);
        cyc = 0;
        repeat (50) begin
            @(negedge clk);
            if (mdc) cyc++;
        end
        chk("R9 mdc idle after reset", 64'(cyc), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_registers();
        t_write(1'b0);
        t_read(8'hE5, 8'h3F, 16'h8C31, 16'h0000);
        t_write_keeps_rdata(16'h8C31);
        t_read(8'h1F, 8'h00, 16'h0001, 16'h8C31);
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule